// File: doc/BRIEF.md
# Shifted-Operand Integer Execute Stage

This block is the integer execute stage of a single-issue, 32-bit register-based pipeline. Each cycle the issue logic may present one decoded data-processing operation together with two register operands, a destination hint and a shift description for the second operand. The unit shifts that operand if needed, performs the logical, arithmetic, compare, move or leading-zero operation, and registers the result, a write enable, the condition flags and an illegal-operation indication.

The second operand may be passed through, shifted by a 5-bit immediate, or shifted by an amount held in a third register. The register-amount form cannot fit in one issue slot. During its first cycle the unit samples only the amount register and raises `busy`, so issue holds the same operation for one more cycle. During that second cycle the unit reads the two operands and completes the operation. The register file, forwarding, program-counter writes, branches and condition evaluation belong to other blocks.

Top module: `dp_exec_unit`

## Requirements
- R1: An operation issued with `issue_valid` high and `busy` low produces `res_valid` high one cycle later. With no shift, with an immediate shift, and for leading-zero count under any shift source, `busy` stays low, so the operation takes a single cycle.
- R2: With `shift_src`=2 (register amount) and an operation other than leading-zero count, `busy` is high in the first cycle only. In that cycle bits [7:0] of `shift_reg` are sampled and the other operand inputs are ignored. `res_valid` stays low after the first cycle and goes high after the second, which uses `opnd_a`, `opnd_b` and the other fields as presented in that second cycle.
- R3: Opcode encoding: 0 AND, 1 EOR, 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC, 6 SBC (a-b-!C), 7 RSC (b-a-!C), 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC (a & ~b), 15 MVN, 16 CLZ. Here b is the shifted second operand and C is the carry bit of `flags_in`.
- R4: `shift_type` encoding: 0 LSL, 1 LSR, 2 ASR, 3 ROR. For a register amount n: if n=0, the operand and carry pass through. For n≥32, LSL and LSR give 0, with carry equal to the last bit shifted out when n=32 and 0 when n>32. ASR with n≥32 fills with the sign bit and takes the sign as carry. ROR rotates by n mod 32, and its carry is result bit 31.
- R5: `shift_src` encoding: 0 none, 1 immediate, 2 register. An immediate amount of 0 means no shift for LSL, a 32-bit shift for LSR and ASR, and for ROR a one-bit rotate right through the carry (carry in at bit 31, bit 0 out as carry).
- R6: The flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V. Logical operations and moves set N and Z from the result, take C from the shifter carry-out and keep V. Arithmetic operations set C to the unsigned carry (no borrow for subtraction) and V to the signed overflow.
- R7: TST, TEQ, CMP and CMN always update the flags (`flags_wr` high) and never write a register (`wr_en` low).
- R8: Any other operation with `set_flags` low leaves `flags_wr` low and returns `flags_out` equal to the `flags_in` it was issued with.
- R9: CLZ returns the number of leading zeros of the unshifted `opnd_b`, which is 32 for a zero input. It never updates the flags.
- R10: CLZ with `dest_pc` high gives `illegal` high and `wr_en` and `flags_wr` low.
- R11: After reset, and in any cycle without a result, `res_valid`, `wr_en`, `flags_wr` and `illegal` are low. Directly after reset `busy`, `result` and `flags_out` are also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (R3) |
| set_flags | input | 1 | Request a flag update for non-compare operations |
| dest_pc | input | 1 | Destination is the program counter |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand, the one that is shifted |
| shift_src | input | 2 | Shift amount source (R5) |
| shift_type | input | 2 | Shift kind (R4) |
| shift_imm | input | 5 | Immediate shift amount |
| shift_reg | input | 32 | Register holding the shift amount |
| flags_in | input | 4 | Current NZCV flags |
| busy | output | 1 | Stall issue for one cycle |
| res_valid | output | 1 | Result outputs are valid this cycle |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Write the result to the destination |
| flags_wr | output | 1 | Commit `flags_out` |
| flags_out | output | 4 | New NZCV flags |
| illegal | output | 1 | Unpredictable operation was issued |

## Verification
Single-cycle forms and CLZ must show their registered outputs at the first falling edge after the issuing rising edge. The register-shift form must show no result at that edge and its full result one edge later. The bench drives stimulus at the falling edge and checks `busy` combinationally shortly afterwards. It then checks the result at the next falling edge, and for two-cycle forms also at the edge after that, so each comparison lands in the cycle the result is due. Between the two cycles of a register shift, the bench swaps `opnd_a` in for garbage and `shift_reg` out for garbage. A wrong sampling cycle therefore shows up as a wrong value rather than staying hidden. Every cycle is compared against a behavioural model that shifts bit by bit and evaluates arithmetic in 64-bit signed and unsigned integers.

// File: rtl/dp_exec_unit.sv
module dp_exec_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid,
  input  logic [4:0]           op,
  input  logic                 set_flags,
  input  logic                 dest_pc,
  input  logic [W-1:0]         opnd_a,
  input  logic [W-1:0]         opnd_b,
  input  logic [1:0]           shift_src,
  input  logic [1:0]           shift_type,
  input  logic [$clog2(W)-1:0] shift_imm,
  input  logic [W-1:0]         shift_reg,
  input  logic [3:0]           flags_in,
  output logic                 busy,
  output logic                 res_valid,
  output logic [W-1:0]         result,
  output logic                 wr_en,
  output logic                 flags_wr,
  output logic [3:0]           flags_out,
  output logic                 illegal
);
  localparam int SW = $clog2(W);
  localparam logic [8:0] WAMT = 9'(W);

  logic       stage2_q;
  logic [7:0] amt_q;
  logic       unused_hi;
  assign unused_hi = ^shift_reg[W-1:8];

  wire is_clz  = (op == 5'd16);
  wire is_cmp  = (op >= 5'd8) && (op <= 5'd11);
  wire cin     = flags_in[1];
  wire accept  = issue_valid && !busy;
  assign busy  = issue_valid && (shift_src == 2'd2) && !is_clz && !stage2_q;

  logic [8:0] amt, asr_amt;
  logic       use_sh, rrx;
  always_comb begin
    use_sh = 1'b1;
    rrx    = 1'b0;
    amt    = 9'd0;
    case (shift_src)
      2'd0: use_sh = 1'b0;
      2'd1: begin
        amt = 9'(shift_imm);
        if (shift_imm == '0) begin
          if (shift_type == 2'd1 || shift_type == 2'd2) amt = WAMT;
          if (shift_type == 2'd3) rrx = 1'b1;
        end
      end
      default: amt = {1'b0, amt_q};
    endcase
    asr_amt = (amt > WAMT) ? WAMT : amt;
  end

  logic [W:0]   lsl_t, lsr_t, asr_t;
  logic [W-1:0] ror_r, sh_val;
  logic         sh_c;
  assign lsl_t = {1'b0, opnd_b} << amt;
  assign lsr_t = {opnd_b, 1'b0} >> amt;
  assign asr_t = $signed({opnd_b, 1'b0}) >>> asr_amt;
  assign ror_r = (opnd_b >> amt[SW-1:0]) | (opnd_b << ((SW+1)'(W) - {1'b0, amt[SW-1:0]}));

  always_comb begin
    sh_val = opnd_b;
    sh_c   = cin;
    if (rrx) begin
      sh_val = {cin, opnd_b[W-1:1]};
      sh_c   = opnd_b[0];
    end else if (use_sh && amt != 9'd0) begin
      case (shift_type)
        2'd0:    begin sh_val = lsl_t[W-1:0]; sh_c = lsl_t[W];   end
        2'd1:    begin sh_val = lsr_t[W:1];   sh_c = lsr_t[0];   end
        2'd2:    begin sh_val = asr_t[W:1];   sh_c = asr_t[0];   end
        default: begin sh_val = ror_r;        sh_c = ror_r[W-1]; end
      endcase
    end
  end

  logic [SW:0] clz_n;
  always_comb begin
    clz_n = (SW+1)'(W);
    for (int i = 0; i < W; i++)
      if (opnd_b[i]) clz_n = (SW+1)'(W - 1 - i);
  end

  logic [W-1:0] ax, ay, alu_r;
  logic         aci, arith;
  logic [W:0]   sum;
  always_comb begin
    ax = opnd_a; ay = sh_val; aci = 1'b0; arith = 1'b1;
    case (op)
      5'd2, 5'd10: begin ay = ~sh_val; aci = 1'b1; end
      5'd3:        begin ax = sh_val; ay = ~opnd_a; aci = 1'b1; end
      5'd5:        aci = cin;
      5'd6:        begin ay = ~sh_val; aci = cin; end
      5'd7:        begin ax = sh_val; ay = ~opnd_a; aci = cin; end
      5'd4, 5'd11: ;
      default:     arith = 1'b0;
    endcase
    sum = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, aci};
    case (op)
      5'd0, 5'd8:  alu_r = opnd_a & sh_val;
      5'd1, 5'd9:  alu_r = opnd_a ^ sh_val;
      5'd12:       alu_r = opnd_a | sh_val;
      5'd13:       alu_r = sh_val;
      5'd14:       alu_r = opnd_a & ~sh_val;
      5'd15:       alu_r = ~sh_val;
      5'd16:       alu_r = {{(W-SW-1){1'b0}}, clz_n};
      default:     alu_r = sum[W-1:0];
    endcase
  end

  wire ovf = (ax[W-1] == ay[W-1]) && (sum[W-1] != ax[W-1]);
  wire upd = is_cmp || (set_flags && !is_clz);
  wire [3:0] new_f = {alu_r[W-1], alu_r == '0,
                      arith ? sum[W] : sh_c,
                      arith ? ovf : flags_in[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage2_q  <= 1'b0;
      amt_q     <= '0;
      res_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flags_wr  <= 1'b0;
      flags_out <= '0;
      illegal   <= 1'b0;
    end else begin
      stage2_q  <= busy;
      if (busy) amt_q <= shift_reg[7:0];
      res_valid <= accept;
      wr_en     <= accept && !is_cmp && !(is_clz && dest_pc);
      flags_wr  <= accept && upd;
      illegal   <= accept && is_clz && dest_pc;
      if (accept) begin
        result    <= alu_r;
        flags_out <= upd ? new_f : flags_in;
      end
    end
  end
endmodule

module dp_exec_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_valid,
  input logic [4:0]   op,
  input logic         busy,
  input logic         res_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         flags_wr,
  input logic [3:0]   flags_out,
  input logic         illegal
);
  a_r2_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r2_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !res_valid);
  a_r1_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy) |=> res_valid);
  a_r7_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy && op >= 5'd8 && op <= 5'd11) |=> (!wr_en && flags_wr));
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !flags_wr));
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flags_wr |-> (flags_out[2] == (result == '0)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!wr_en && !flags_wr && !illegal));
endmodule

bind dp_exec_unit dp_exec_unit_chk #(.W(W)) u_chk (.*);

// File: tb/dp_exec_unit_tb.sv
`timescale 1ns/1ps
module dp_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [4:0]  op = '0;
  logic        set_flags = 1'b0, dest_pc = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, shift_reg = '0;
  logic [1:0]  shift_src = '0, shift_type = '0;
  logic [4:0]  shift_imm = '0;
  logic [3:0]  flags_in = '0;
  logic        busy, res_valid, wr_en, flags_wr, illegal;
  logic [31:0] result;
  logic [3:0]  flags_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dp_exec_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ref_shift(input logic [31:0] v, input int src, input int typ, input int imm,
                           input logic [31:0] rs, input bit ci, output logic [31:0] r, output bit c);
    int n;
    r = v; c = ci;
    if (src == 0) return;
    if (src == 1) begin
      n = imm;
      if (imm == 0 && typ == 3) begin c = v[0]; r = {ci, v[31:1]}; return; end
      if (imm == 0 && (typ == 1 || typ == 2)) n = 32;
    end else n = int'(rs[7:0]);
    for (int i = 0; i < n; i++)
      case (typ)
        0: begin c = r[31]; r = r << 1; end
        1: begin c = r[0]; r = r >> 1; end
        2: begin c = r[0]; r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
  endtask

  task automatic issue(input string tag, input int o, input bit sf, input bit dpc,
                       input logic [31:0] a, input logic [31:0] b, input int src, input int typ,
                       input int imm, input logic [31:0] rs, input logic [3:0] fl);
    logic [31:0] bs, er;
    bit sc, ec, ev, two, cmp, upd;
    longint ua, ub, sa, sb, ures, sres;
    int ci;
    logic [3:0] ef;
    ref_shift(b, src, typ, imm, rs, fl[1], bs, sc);
    ci = fl[1];
    ua = longint'({32'b0, a}); ub = longint'({32'b0, bs});
    sa = longint'($signed(a)); sb = longint'($signed(bs));
    ures = 0; sres = 0; ec = sc; ev = fl[0];
    case (o)
      4, 11: begin ures = ua + ub; sres = sa + sb; end
      5:     begin ures = ua + ub + ci; sres = sa + sb + ci; end
      2, 10: begin ures = ua - ub; sres = sa - sb; end
      6:     begin ures = ua - ub - (1 - ci); sres = sa - sb - (1 - ci); end
      3:     begin ures = ub - ua; sres = sb - sa; end
      7:     begin ures = ub - ua - (1 - ci); sres = sb - sa - (1 - ci); end
      default: ;
    endcase
    case (o)
      0, 8: er = a & bs;
      1, 9: er = a ^ bs;
      12:   er = a | bs;
      13:   er = bs;
      14:   er = a & ~bs;
      15:   er = ~bs;
      16: begin er = 32; for (int i = 31; i >= 0; i--) if (b[i] && er == 32) er = 31 - i; end
      default: begin
        er = ures[31:0];
        ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
        ec = (o == 4 || o == 5 || o == 11) ? (ures > 64'h0FFFF_FFFF) : (ures >= 0);
      end
    endcase
    cmp = (o >= 8 && o <= 11);
    upd = cmp || (sf && o != 16);
    ef  = upd ? {er[31], er == 0, ec, ev} : fl;
    two = (src == 2) && (o != 16);

    op = 5'(o); set_flags = sf; dest_pc = dpc; opnd_b = b;
    shift_src = 2'(src); shift_type = 2'(typ); shift_imm = 5'(imm); flags_in = fl;
    shift_reg = rs; opnd_a = two ? (a ^ 32'hDEAD_BEEF) : a;
    issue_valid = 1'b1;
    #1;
    chk(busy == two, two ? "R2 busy first cycle" : "R1 no stall", 32'(busy), 32'(two));
    @(posedge clk); @(negedge clk);
    if (two) begin
      chk(!res_valid, "R2 no result after first cycle", 32'(res_valid), 0);
      opnd_a = a; shift_reg = ~rs;
      #1;
      chk(!busy, "R2 busy second cycle", 32'(busy), 0);
      @(posedge clk); @(negedge clk);
    end
    issue_valid = 1'b0;
    chk(res_valid, two ? "R2 result valid" : "R1 result valid", 32'(res_valid), 1);
    chk(result == er, tag, result, er);
    chk(flags_out == ef, (o == 16) ? "R9 flags" : (upd ? "R6 flags" : "R8 flags kept"), 32'(flags_out), 32'(ef));
    chk(flags_wr == upd, cmp ? "R7 flag write" : "R8 flag write", 32'(flags_wr), 32'(upd));
    chk(wr_en == !(cmp || (o == 16 && dpc)), cmp ? "R7 no register write" : "R10 write enable",
        32'(wr_en), 32'(!(cmp || (o == 16 && dpc))));
    chk(illegal == (o == 16 && dpc), "R10 illegal", 32'(illegal), 32'(o == 16 && dpc));
    @(posedge clk); @(negedge clk);
    chk(!res_valid && !wr_en && !flags_wr && !illegal, "R11 idle cycle",
        {28'b0, res_valid, wr_en, flags_wr, illegal}, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && !busy && !wr_en && !flags_wr && !illegal, "R11 reset outputs",
        {27'b0, res_valid, busy, wr_en, flags_wr, illegal}, 0);
    chk(result == 0 && flags_out == 0, "R11 reset values", result | 32'(flags_out), 0);

    issue("R3 ADD plain",   4, 1, 0, 32'd7, 32'd5, 0, 0, 0, 0, 4'b0000);
    issue("R3 ADC carry",   5, 1, 0, 32'hFFFF_FFFF, 32'd0, 0, 0, 0, 0, 4'b0010);
    issue("R3 SUB borrow",  2, 1, 0, 32'd3, 32'd5, 0, 0, 0, 0, 4'b0000);
    issue("R3 RSB",         3, 1, 0, 32'd3, 32'd10, 0, 0, 0, 0, 4'b0000);
    issue("R3 SBC",         6, 1, 0, 32'd10, 32'd3, 0, 0, 0, 0, 4'b0000);
    issue("R3 RSC",         7, 1, 0, 32'd3, 32'd10, 0, 0, 0, 0, 4'b0010);
    issue("R7 CMP equal",  10, 0, 0, 32'd42, 32'd42, 0, 0, 0, 0, 4'b0000);
    issue("R6 CMN overflow",11, 0, 0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, 4'b0000);
    issue("R7 TST",         8, 0, 0, 32'hF0, 32'h0F, 0, 0, 0, 0, 4'b0001);
    issue("R7 TEQ",         9, 0, 0, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 4'b0000);
    issue("R4 AND LSL imm", 0, 1, 0, 32'hFFFF_FFFF, 32'h8000_0001, 1, 0, 1, 0, 4'b0001);
    issue("R5 ORR LSR #0",  12, 1, 0, 32'h0, 32'h8000_0000, 1, 1, 0, 0, 4'b0000);
    issue("R5 EOR ASR #0",  1, 1, 0, 32'h0, 32'h8000_0000, 1, 2, 0, 0, 4'b0000);
    issue("R5 BIC RRX",     14, 1, 0, 32'hFFFF_FFFF, 32'h3, 1, 3, 0, 0, 4'b0010);
    issue("R5 MOV LSL #0",  13, 1, 0, 32'h0, 32'h1234_5678, 1, 0, 0, 0, 4'b0010);
    issue("R4 MOV LSL 32",  13, 1, 0, 32'h0, 32'h0000_0001, 2, 0, 0, 32'd32, 4'b0000);
    issue("R4 MOV LSR 33",  13, 1, 0, 32'h0, 32'hFFFF_FFFF, 2, 1, 0, 32'd33, 4'b0010);
    issue("R4 MOV ASR 40",  13, 1, 0, 32'h0, 32'h8000_0000, 2, 2, 0, 32'd40, 4'b0000);
    issue("R4 MOV ROR 32",  13, 1, 0, 32'h0, 32'h8000_0001, 2, 3, 0, 32'd32, 4'b0000);
    issue("R4 ROR low byte zero", 13, 1, 0, 32'h0, 32'hABCD_0001, 2, 3, 0, 32'h100, 4'b0010);
    issue("R2 ADD reg LSL 4", 4, 1, 0, 32'd1, 32'h0000_00F0, 2, 0, 0, 32'd4, 4'b0000);
    issue("R3 MVN",         15, 0, 0, 32'h0, 32'h0F0F_0F0F, 0, 0, 0, 0, 4'b1111);
    issue("R8 ADD no flags", 4, 0, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 4'b1010);
    issue("R9 CLZ zero",    16, 1, 0, 32'h0, 32'h0, 0, 0, 0, 0, 4'b0000);
    issue("R9 CLZ value",   16, 0, 0, 32'h0, 32'h0001_0000, 0, 0, 0, 0, 4'b0000);
    issue("R9 CLZ reg shift ignored", 16, 0, 0, 32'h0, 32'h0000_0100, 2, 0, 0, 32'd3, 4'b0000);
    issue("R10 CLZ to PC",  16, 0, 1, 32'h0, 32'h4, 0, 0, 0, 0, 4'b0000);

    for (int k = 0; k < 400; k++) begin
      int o, s;
      o = int'($urandom_range(0, 16));
      s = int'($urandom_range(0, 2));
      issue("R3 random op", o, 1'($urandom), ($urandom_range(0, 7) == 0),
            $urandom, $urandom, s, int'($urandom_range(0, 3)),
            int'($urandom_range(0, 31)), ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 40)) : $urandom,
            4'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule